// File: doc/BRIEF.md
# GPIO Port Register Block

This block gives a small 8-bit processor five general-purpose I/O ports of eight pins each. Each port has a direction register and an output latch. Pull-up enables are controlled by two shared registers, mostly one control bit per pair of pins, and a mode register holds the output drive-strength select. Software reaches every register through a synchronous register interface with a single address bus, separate write and read strobes, and registered read data. On the pad side, each pin has an output value, an output enable, a pull-up enable and an input level.

Reading a port data register gives a different value for each pin, depending on its direction. Output pins return the latch and input pins return the pad level after synchronization. Writing to an input pin updates only its latch, so that value reaches the pad once the pin is switched to output. A pull-up is applied only to a pin that is an input and has its control bit set.

The address map uses an 8-bit address. Port p (0 to 4) has its data register at 2p and its direction register at 2p+1. The pull-up control registers are at 0x10 (A) and 0x11 (B), and the mode register is at 0x14. Pin b of port p maps to flat pad index 8p+b.

Top module: `gpio_regblock`

## Requirements
- R1: After reset, every pad_oe, pad_out and pad_pu bit is 0, drive_weak is 0, and every mapped register reads 0 while the pads are low.
- R2: A direction bit of 1 makes its pin an output and a 0 makes it an input. pad_oe equals the direction register and pad_out always equals the output latch. The direction register reads back at address 2p+1.
- R3: Reading the data register at 2p returns the output latch in every bit position whose direction bit is 1.
- R4: Reading the data register returns the pad level in every bit position whose direction bit is 0. The pad goes through a two-flop synchronizer, so a pad change appears in reads issued two or more cycles after the change, and not in reads issued zero or one cycle after it.
- R5: A write to the data register while a pin is an input updates the latch on pad_out, and pad_oe stays 0. The stored value drives the pin as soon as the pin is switched to output.
- R6: pad_pu of a pin is 1 only when its control bit is 1 and its direction bit is 0. Register A: bits 0–3 control port 0 pin pairs 0/1, 2/3, 4/5 and 6/7. Bit 4 controls port 1 pin 1, bit 5 controls port 1 pins 2/3 and bit 6 controls port 1 pins 4/5. Register B: bits 0–3 control port 2 pairs in the same order as register A. Bit 4 controls port 3 pins 4/5, bit 5 controls port 3 pins 6/7 and bit 6 controls port 4 pins 0/1. All other pins have no pull-up.
- R7: Bit 7 of both pull-up control registers is not stored and always reads 0. Bits 0–6 read back as written.
- R8: Bit 7 of the mode register drives drive_weak (1 = weak drive, 0 = strong drive). A read returns that bit in position 7 with bits 0–6 as 0.
- R9: A read of any address other than 0x00–0x09, 0x10, 0x11 and 0x14 returns 0, and a write to such an address changes no register or pad output.
- R10: rd_data holds the value addressed in the previous cycle when rd_en was 1 in that cycle, and 0 otherwise. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data, valid the cycle after rd_en |
| pad_in | input | 40 | Pad input levels, flat index 8p+b |
| pad_out | output | 40 | Output latch values to the pads |
| pad_oe | output | 40 | Pad output enables |
| pad_pu | output | 40 | Pad pull-up enables |
| drive_weak | output | 1 | Weak drive select for the output drivers |

## Verification
The assertions check the following on every cycle:
- No pin ever has both its pull-up and its output enable set.
- The read data is 0 after a cycle with no read and after a read of an unmapped address.
- The unused pull-up bit and the mode register read back in their defined forms.
- Direction readback and latch readback for output pins on port 0 agree with the pad-side outputs.
- A write to an unmapped address leaves every pad output unchanged.

Only the bench scenarios can show the following:
- The pull-up pin-pair mapping for every control value.
- The exact two-cycle latency of the synchronizer.
- That a latch written while the pin is an input drives the pad once the pin becomes an output.
- That a read returns the value from before a write in the same cycle.

// File: rtl/gpio_regblock_pkg.sv
// Package: shared sizes, register addresses and the pull-up pin map.
// Assumes fixed 8-pin ports; the pull-up map is defined for five ports.
package gpio_regblock_pkg;
    localparam int PORTS     = 5;
    localparam int PIN_W     = 8;
    localparam int PINS      = PORTS * PIN_W;
    localparam int REG_W     = 8;
    localparam int ADR_PU_A  = 'h10;
    localparam int ADR_PU_B  = 'h11;
    localparam int ADR_MODE  = 'h14;
    localparam int WEAK_BIT  = 7;
    localparam logic [REG_W-1:0] PU_MASK = 8'h7F;

    // Expand the two pull-up control registers into a per-pin control map.
    function automatic logic [PINS-1:0] pullup_map(input logic [REG_W-1:0] ctl_a,
                                                   input logic [REG_W-1:0] ctl_b);
        logic [PINS-1:0] m;
        m = '0;
        for (int b = 0; b < PIN_W; b++) begin
            m[0*PIN_W + b] = ctl_a[b/2];
            m[2*PIN_W + b] = ctl_b[b/2];
        end
        m[1*PIN_W + 1] = ctl_a[4];
        m[1*PIN_W + 2] = ctl_a[5];
        m[1*PIN_W + 3] = ctl_a[5];
        m[1*PIN_W + 4] = ctl_a[6];
        m[1*PIN_W + 5] = ctl_a[6];
        m[3*PIN_W + 4] = ctl_b[4];
        m[3*PIN_W + 5] = ctl_b[4];
        m[3*PIN_W + 6] = ctl_b[5];
        m[3*PIN_W + 7] = ctl_b[5];
        m[4*PIN_W + 0] = ctl_b[6];
        m[4*PIN_W + 1] = ctl_b[6];
        return m;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
// Module: multi-stage flop synchronizer for pad inputs.
// Assumes STAGES >= 1; all stages reset to 0.
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the asynchronous pad level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= '0;
                else        chain[0] <= d;
            end
        end else begin : g_next
            // Later stages pass the value down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_port.sv
// Module: one port: direction register, output latch and read selection.
// Assumes write enables are already decoded; pad_sync is synchronized.
module gpio_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lat_we,
    input  logic         dir_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pad_sync,
    output logic [W-1:0] latch,
    output logic [W-1:0] dir,
    output logic [W-1:0] rd_val
);
    // Output latch: written regardless of pin direction.
    always_ff @(posedge clk) begin
        if (!rst_n)      latch <= '0;
        else if (lat_we) latch <= wdata;
    end

    // Direction register: 1 = output, 0 = input.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir <= '0;
        else if (dir_we) dir <= wdata;
    end

    // Read value: latch for output pins, synchronized pad for input pins.
    always_comb begin
        rd_val = (dir & latch) | (~dir & pad_sync);
    end
endmodule

// File: rtl/gpio_pullup_map.sv
// Module: combines pull-up control bits with pin direction.
// Assumes dir uses the flat pin index 8p+b.
module gpio_pullup_map
    import gpio_regblock_pkg::*;
(
    input  logic [REG_W-1:0] ctl_a,
    input  logic [REG_W-1:0] ctl_b,
    input  logic [PINS-1:0]  dir,
    output logic [PINS-1:0]  pu
);
    // A pull-up applies only to input pins whose control bit is set.
    always_comb begin
        pu = pullup_map(ctl_a, ctl_b) & ~dir;
    end
endmodule

// File: rtl/gpio_regblock.sv
// Module: GPIO register block top: decode, shared registers, read path.
// Assumes single-cycle write strobes; read data is registered one cycle.
module gpio_regblock
    import gpio_regblock_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_en,
    output logic [REG_W-1:0]  rd_data,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_pu,
    output logic              drive_weak
);
    logic [PINS-1:0]  pad_s;
    logic [PORTS-1:0] lat_we, dir_we;
    logic [PORTS-1:0][PIN_W-1:0] lat_q, dir_q, port_rd;
    logic [REG_W-1:0] pu_a, pu_b, rd_mux;
    logic             weak_q;

    gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_s)
    );

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        // Decode the data and direction addresses of this port.
        always_comb begin
            lat_we[p] = wr_en && (addr == ADDR_W'(2*p));
            dir_we[p] = wr_en && (addr == ADDR_W'(2*p + 1));
        end

        gpio_port #(.W(PIN_W)) u_port (
            .clk(clk), .rst_n(rst_n),
            .lat_we(lat_we[p]), .dir_we(dir_we[p]),
            .wdata(wr_data),
            .pad_sync(pad_s[p*PIN_W +: PIN_W]),
            .latch(lat_q[p]), .dir(dir_q[p]), .rd_val(port_rd[p])
        );

        assign pad_out[p*PIN_W +: PIN_W] = lat_q[p];
        assign pad_oe[p*PIN_W +: PIN_W]  = dir_q[p];
    end

    // Shared pull-up control registers; bit 7 is not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pu_a <= '0;
            pu_b <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(ADR_PU_A)) pu_a <= wr_data & PU_MASK;
            if (addr == ADDR_W'(ADR_PU_B)) pu_b <= wr_data & PU_MASK;
        end
    end

    // Mode register: only the drive-strength bit is stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     weak_q <= 1'b0;
        else if (wr_en && addr == ADDR_W'(ADR_MODE))    weak_q <= wr_data[WEAK_BIT];
    end

    assign drive_weak = weak_q;

    gpio_pullup_map u_pu (
        .ctl_a(pu_a), .ctl_b(pu_b), .dir(pad_oe), .pu(pad_pu)
    );

    // Read multiplexer: unmapped addresses give 0.
    always_comb begin
        rd_mux = '0;
        for (int p = 0; p < PORTS; p++) begin
            if (addr == ADDR_W'(2*p))     rd_mux = port_rd[p];
            if (addr == ADDR_W'(2*p + 1)) rd_mux = dir_q[p];
        end
        if (addr == ADDR_W'(ADR_PU_A)) rd_mux = pu_a;
        if (addr == ADDR_W'(ADR_PU_B)) rd_mux = pu_b;
        if (addr == ADDR_W'(ADR_MODE)) rd_mux = {weak_q, 7'b0};
    end

    // Registered read data: the value is held only for the cycle after a read.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
        else            rd_data <= '0;
    end
endmodule

// File: rtl/gpio_regblock_chk.sv
// Module: assertion checker bound to gpio_regblock; observes ports only.
// Assumes the address map of the block's brief.
module gpio_regblock_chk
    import gpio_regblock_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [REG_W-1:0]  rd_data,
    input logic [PINS-1:0]   pad_out,
    input logic [PINS-1:0]   pad_oe,
    input logic [PINS-1:0]   pad_pu,
    input logic              drive_weak
);
    logic mapped;

    // Flags whether the current address selects any register.
    always_comb begin
        mapped = (addr < ADDR_W'(2*PORTS)) || (addr == ADDR_W'(ADR_PU_A)) ||
                 (addr == ADDR_W'(ADR_PU_B)) || (addr == ADDR_W'(ADR_MODE));
    end

    assert_pu_input_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rd_data == '0);

    assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |=> rd_data == '0);

    assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mapped) |=> ($stable(pad_out) && $stable(pad_oe) &&
                                $stable(pad_pu) && $stable(drive_weak)));

    assert_pu_top_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == ADDR_W'(ADR_PU_A) || addr == ADDR_W'(ADR_PU_B)))
        |=> rd_data[7] == 1'b0);

    assert_mode_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(ADR_MODE)) |=> rd_data == {$past(drive_weak), 7'b0});

    assert_dir_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(1)) |=> rd_data == $past(pad_oe[PIN_W-1:0]));

    assert_latch_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(0)) |=>
        (rd_data & $past(pad_oe[PIN_W-1:0])) ==
        ($past(pad_out[PIN_W-1:0]) & $past(pad_oe[PIN_W-1:0])));
endmodule

bind gpio_regblock gpio_regblock_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .rd_data(rd_data), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .drive_weak(drive_weak)
);

// File: tb/gpio_regblock_tb_top.sv
// Bench: sweeps of directions, latches, pads and pull-up controls,
// with a bench-side register model built from the requirements.
module gpio_regblock_tb_top;
    localparam int NP = 5;
    localparam int NPINS = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0]       addr = '0;
    logic             wr_en = 1'b0;
    logic [7:0]       wr_data = '0;
    logic             rd_en = 1'b0;
    logic [7:0]       rd_data;
    logic [NPINS-1:0] pad_in = '0;
    logic [NPINS-1:0] pad_out, pad_oe, pad_pu;
    logic             drive_weak;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] m_lat [NP];
    logic [7:0] m_dir [NP];
    logic [7:0] m_pua = '0, m_pub = '0;
    logic       m_weak = 1'b0;

    always #10 clk = ~clk;

    gpio_regblock dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu(pad_pu), .drive_weak(drive_weak)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit is_mapped(input int a);
        return (a < 10) || (a == 'h10) || (a == 'h11) || (a == 'h14);
    endfunction

    function automatic void model_write(input int a, input logic [7:0] d);
        if (a < 10) begin
            if (a % 2 == 0) m_lat[a/2] = d;
            else            m_dir[a/2] = d;
        end else if (a == 'h10) m_pua = d & 8'h7F;
        else if (a == 'h11)     m_pub = d & 8'h7F;
        else if (a == 'h14)     m_weak = d[7];
    endfunction

    function automatic logic [7:0] exp_read(input int a);
        if (a < 10) begin
            if (a % 2 == 1) return m_dir[a/2];
            return (m_dir[a/2] & m_lat[a/2]) | (~m_dir[a/2] & pad_in[(a/2)*8 +: 8]);
        end
        if (a == 'h10) return m_pua;
        if (a == 'h11) return m_pub;
        if (a == 'h14) return {m_weak, 7'b0};
        return 8'h00;
    endfunction

    function automatic logic [NPINS-1:0] exp_out();
        logic [NPINS-1:0] v;
        for (int p = 0; p < NP; p++) v[p*8 +: 8] = m_lat[p];
        return v;
    endfunction

    function automatic logic [NPINS-1:0] exp_oe();
        logic [NPINS-1:0] v;
        for (int p = 0; p < NP; p++) v[p*8 +: 8] = m_dir[p];
        return v;
    endfunction

    // Pull-up expectation from the pin-pair table of R6.
    function automatic logic [NPINS-1:0] exp_pu();
        logic [NPINS-1:0] v;
        logic c;
        for (int p = 0; p < NP; p++) begin
            for (int b = 0; b < 8; b++) begin
                case (p)
                    0: c = m_pua[b >> 1];
                    1: c = (b == 1) ? m_pua[4] : (b == 2 || b == 3) ? m_pua[5] :
                           (b == 4 || b == 5) ? m_pua[6] : 1'b0;
                    2: c = m_pub[b >> 1];
                    3: c = (b >= 6) ? m_pub[5] : (b >= 4) ? m_pub[4] : 1'b0;
                    default: c = (b < 2) ? m_pub[6] : 1'b0;
                endcase
                v[p*8 + b] = c & ~m_dir[p][b];
            end
        end
        return v;
    endfunction

    // Caller is at a falling edge; returns at the next falling edge.
    task automatic wr(input int a, input logic [7:0] d);
        addr = 8'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        addr = 8'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic check_pads(input string req);
        check(req, "pad_out", 64'(pad_out), 64'(exp_out()));
        check(req, "pad_oe", 64'(pad_oe), 64'(exp_oe()));
        check(req, "pad_pu", 64'(pad_pu), 64'(exp_pu()));
        check(req, "drive_weak", 64'(drive_weak), 64'(m_weak));
    endtask

    task automatic check_all_regs(input string req);
        logic [7:0] d;
        for (int a = 0; a < 256; a++) begin
            if (is_mapped(a)) begin
                rd(a, d);
                check(req, $sformatf("read addr %0h", a), 64'(d), 64'(exp_read(a)));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] pats [5];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C; pats[4] = 8'h5A;
        for (int p = 0; p < NP; p++) begin m_lat[p] = '0; m_dir[p] = '0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the pads and through every register.
        check_pads("R1");
        check_all_regs("R1");

        // R2, R3, R4: direction/latch/pad patterns on every port.
        for (int p = 0; p < NP; p++) begin
            for (int k = 0; k < 5; k++) begin
                wr(2*p, pats[k]);
                wr(2*p + 1, pats[(k + 2) % 5]);
                pad_in[p*8 +: 8] = pats[(k + 1) % 5] ^ 8'h0F;
                repeat (2) @(negedge clk);
                check_pads("R2");
                rd(2*p + 1, d);
                check("R2", "dir readback", 64'(d), 64'(m_dir[p]));
                rd(2*p, d);
                check("R3 R4", "data read", 64'(d), 64'(exp_read(2*p)));
            end
        end

        // R4: synchronizer latency on port 0 set to inputs.
        wr(1, 8'h00);
        pad_in[7:0] = 8'h00;
        repeat (3) @(negedge clk);
        pad_in[7:0] = 8'hFF;
        rd(0, d); check("R4", "read 0 cycles after change", 64'(d), 64'h00);
        rd(0, d); check("R4", "read 1 cycle after change", 64'(d), 64'h00);
        rd(0, d); check("R4", "read 2 cycles after change", 64'(d), 64'hFF);

        // R5: write to input pins reaches the latch but not the enable.
        wr(5, 8'h00);
        wr(4, 8'h96);
        check("R5", "pad_oe port 2", 64'(pad_oe[23:16]), 64'h00);
        check("R5", "pad_out port 2", 64'(pad_out[23:16]), 64'h96);
        wr(5, 8'hFF);
        check("R5", "pad_oe port 2 after dir", 64'(pad_oe[23:16]), 64'hFF);
        rd(4, d); check("R5", "latched value read", 64'(d), 64'h96);

        // R6: every control value against several direction patterns.
        for (int k = 0; k < 4; k++) begin
            for (int p = 0; p < NP; p++) wr(2*p + 1, pats[k] ^ 8'(p));
            for (int v = 0; v < 256; v++) begin
                wr('h10, 8'(v));
                wr('h11, 8'(255 - v));
                check("R6", $sformatf("pad_pu v=%0d", v), 64'(pad_pu), 64'(exp_pu()));
            end
        end

        // R7: unused top bit of the pull-up registers.
        wr('h10, 8'hFF); rd('h10, d); check("R7", "pull-up A", 64'(d), 64'h7F);
        wr('h11, 8'hFF); rd('h11, d); check("R7", "pull-up B", 64'(d), 64'h7F);
        wr('h11, 8'h2A); rd('h11, d); check("R7", "pull-up B pattern", 64'(d), 64'h2A);

        // R8: drive-strength mode bit.
        wr('h14, 8'hFF);
        check("R8", "drive_weak set", 64'(drive_weak), 64'h1);
        rd('h14, d); check("R8", "mode read set", 64'(d), 64'h80);
        wr('h14, 8'h7F);
        check("R8", "drive_weak clear", 64'(drive_weak), 64'h0);
        rd('h14, d); check("R8", "mode read clear", 64'(d), 64'h00);

        // R9: unmapped addresses read 0 and change nothing.
        wr('h14, 8'h80);
        for (int a = 0; a < 256; a++) begin
            if (!is_mapped(a)) begin
                addr = 8'(a); wr_data = 8'hFF; wr_en = 1'b1;
                @(negedge clk);
                wr_en = 1'b0;
                rd(a, d);
                check("R9", $sformatf("unmapped read %0h", a), 64'(d), 64'h00);
            end
        end
        check_pads("R9");
        check_all_regs("R9");

        // R10: read and write in the same cycle return the old value.
        wr(3, 8'hFF);
        wr(2, 8'h11);
        addr = 8'h02; wr_data = 8'h22; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        model_write(2, 8'h22);
        check("R10", "read during write", 64'(rd_data), 64'h11);
        check("R10", "latch after write", 64'(pad_out[15:8]), 64'h22);
        @(negedge clk);
        check("R10", "idle read data", 64'(rd_data), 64'h00);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule